// File: doc/BRIEF.md
# Channel Ring Command FIFO

This block keeps command words for several channels in one shared RAM. Each channel owns a circular slice of that RAM. The slice is bounded by a programmable first index and last index, and each channel has its own read and write pointer. When a pointer sits on the last index it moves back to the first index. Otherwise it steps up by one. Producers push words into a chosen channel, and consumers pop them out in order. Popped data arrives one cycle after the request, from a synchronous RAM read.

A debug inspection port runs next to the normal traffic. Software writes an inspection control word that selects a channel and a RAM index. While inspection is on, that channel is frozen and its pushes and pops are dropped. All other channels keep running. The block shows the frozen channel's two pointers and its empty flag at all times. It also returns the RAM word at the chosen index one cycle after the control write. Writing zero to the control word ends the inspection.

Top module: `cmd_ring_fifo`

## Requirements
- R1: After reset, channel c owns the slice [c*S, c*S+S-1], where S is the RAM depth divided by the channel count. Both of its pointers sit at c*S. Every channel is empty and none is full. Inspection is off and selects channel 0.
- R2: A setup write to a channel takes the first index from bits 8:0 and the last index from bits 24:16 of `cfg_wdata`. It also moves both of that channel's pointers to the new first index. In that same cycle, a push or pop on that channel is dropped.
- R3: A push to a channel that is neither full nor frozen stores the word at the write pointer and advances the write pointer. A push to a full channel changes nothing.
- R4: A pop from a channel that is neither empty nor frozen raises `pop_dvalid` one cycle later, with the word at the read pointer on `pop_data`, and advances the read pointer. A pop from an empty channel leaves `pop_dvalid` low.
- R5: A pointer equal to the channel's last index advances to its first index. Any other pointer advances by one.
- R6: A channel is empty when its read and write pointers are equal. It is full when advancing its write pointer would make it equal to the read pointer.
- R7: An inspection control word has bit 31 set (enable), the channel in bits 16 and up, and the RAM index in bits 8:0. Writing such a word puts that RAM entry on `peek_data` one cycle later. If a push to that same entry happens in the same cycle, `peek_data` shows the value from before the push.
- R8: `peek_ptrs` shows the selected channel's read pointer in bits 8:0 and its write pointer in bits 24:16. All other bits are zero. Bit 10 of `fifo_stat` is that channel's empty flag, and the other bits are zero.
- R9: While inspection is enabled, pushes and pops to the selected channel are dropped. Pushes and pops to other channels behave normally.
- R10: Writing zero to the inspection control word turns inspection off and unfreezes the channel.
- R11: A push and a pop on the same channel in the same cycle both take effect, as long as that channel is neither full nor empty beforehand.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Setup write strobe |
| cfg_ch | input | $clog2(NCH) | Channel for the setup write |
| cfg_wdata | input | 32 | Setup word: first index in 8:0, last index in 24:16 |
| push_valid | input | 1 | Push request |
| push_ch | input | $clog2(NCH) | Channel to push into |
| push_data | input | DW | Word to push |
| pop_valid | input | 1 | Pop request |
| pop_ch | input | $clog2(NCH) | Channel to pop from |
| pop_dvalid | output | 1 | Popped word valid (one cycle after an accepted pop) |
| pop_data | output | DW | Popped word |
| ch_empty | output | NCH | Per-channel empty flags |
| ch_full | output | NCH | Per-channel full flags |
| peek_we | input | 1 | Inspection control write strobe |
| peek_wdata | input | 32 | Inspection control word |
| peek_ptrs | output | 32 | Selected channel pointers: read in 8:0, write in 24:16 |
| peek_data | output | DW | RAM word at the inspected index |
| fifo_stat | output | 32 | Status; bit 10 is the selected channel's empty flag |

## Verification
A push and a pop can land on the same channel in the same cycle. In that case the two pointer updates must not step on each other, and the full and empty checks must use the state from before the cycle. The bench forces this with directed cycles on a nearly full small ring and on a ring sitting on its wrap boundary. Random traffic repeats the overlap across channels. A reference ring model in the bench judges each case through the pointer view, the flags and the popped word. The same model also covers two other collisions: an inspection read in the same cycle as a push, and a setup write in the same cycle as traffic to the same channel.

// File: rtl/cmd_ring_fifo.sv
module cmd_ring_fifo #(
  parameter int NCH = 4,
  parameter int PW  = 9,
  parameter int DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_ch,
  input  logic [31:0]            cfg_wdata,
  input  logic                   push_valid,
  input  logic [$clog2(NCH)-1:0] push_ch,
  input  logic [DW-1:0]          push_data,
  input  logic                   pop_valid,
  input  logic [$clog2(NCH)-1:0] pop_ch,
  output logic                   pop_dvalid,
  output logic [DW-1:0]          pop_data,
  output logic [NCH-1:0]         ch_empty,
  output logic [NCH-1:0]         ch_full,
  input  logic                   peek_we,
  input  logic [31:0]            peek_wdata,
  output logic [31:0]            peek_ptrs,
  output logic [DW-1:0]          peek_data,
  output logic [31:0]            fifo_stat
);
  localparam int CW    = $clog2(NCH);
  localparam int DEPTH = 2 ** PW;
  localparam int SEG   = DEPTH / NCH;

  logic [PW-1:0] st [NCH];
  logic [PW-1:0] en [NCH];
  logic [PW-1:0] rp [NCH];
  logic [PW-1:0] wp [NCH];
  logic [DW-1:0] mem [DEPTH];
  logic [31:0]   pk_ctrl;
  logic [NCH-1:0] frozen;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p, input logic [PW-1:0] s,
                                        input logic [PW-1:0] e);
    return (p == e) ? s : p + 1'b1;
  endfunction

  wire          pk_on  = pk_ctrl[31];
  wire [CW-1:0] pk_ch  = pk_ctrl[16 +: CW];
  wire [PW-1:0] pk_idx = peek_wdata[PW-1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_flag
    assign ch_empty[c] = rp[c] == wp[c];
    assign ch_full[c]  = nxt(wp[c], st[c], en[c]) == rp[c];
    assign frozen[c]   = pk_on && (pk_ch == CW'(c));
  end

  wire do_push = push_valid && !ch_full[push_ch] && !frozen[push_ch] &&
                 !(cfg_we && cfg_ch == push_ch);
  wire do_pop  = pop_valid && !ch_empty[pop_ch] && !frozen[pop_ch] &&
                 !(cfg_we && cfg_ch == pop_ch);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        st[c] <= PW'(c * SEG);
        en[c] <= PW'(c * SEG + SEG - 1);
        rp[c] <= PW'(c * SEG);
        wp[c] <= PW'(c * SEG);
      end
      pk_ctrl    <= '0;
      pop_dvalid <= 1'b0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (cfg_we && cfg_ch == CW'(c)) begin
          st[c] <= cfg_wdata[PW-1:0];
          en[c] <= cfg_wdata[16 +: PW];
          rp[c] <= cfg_wdata[PW-1:0];
          wp[c] <= cfg_wdata[PW-1:0];
        end else begin
          if (do_push && push_ch == CW'(c)) wp[c] <= nxt(wp[c], st[c], en[c]);
          if (do_pop && pop_ch == CW'(c))   rp[c] <= nxt(rp[c], st[c], en[c]);
        end
      end
      if (peek_we) pk_ctrl <= peek_wdata;
      pop_dvalid <= do_pop;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[push_ch]] <= push_data;
    if (do_pop) pop_data <= mem[rp[pop_ch]];
    if (peek_we && peek_wdata[31]) peek_data <= mem[pk_idx];
  end

  assign peek_ptrs = {{(16-PW){1'b0}}, wp[pk_ch], {(16-PW){1'b0}}, rp[pk_ch]};
  assign fifo_stat = {21'b0, ch_empty[pk_ch], 10'b0};

  logic unused_bits;
  assign unused_bits = ^{cfg_wdata[31:16+PW], cfg_wdata[15:PW], pk_ctrl[30:16+CW], pk_ctrl[15:0]};
endmodule

module cmd_ring_fifo_chk #(
  parameter int NCH = 4,
  parameter int PW  = 9
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cfg_we,
  input logic [$clog2(NCH)-1:0] cfg_ch,
  input logic                   push_valid,
  input logic [$clog2(NCH)-1:0] push_ch,
  input logic                   pop_valid,
  input logic [$clog2(NCH)-1:0] pop_ch,
  input logic                   pop_dvalid,
  input logic [NCH-1:0]         ch_empty,
  input logic [NCH-1:0]         ch_full,
  input logic                   peek_we,
  input logic [31:0]            peek_ptrs,
  input logic [31:0]            fifo_stat,
  input logic [31:0]            pk_ctrl
);
  localparam int CW = $clog2(NCH);
  wire          frz_on = pk_ctrl[31];
  wire [CW-1:0] frz_ch = pk_ctrl[16 +: CW];

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && ch_full[push_ch] && !(cfg_we && cfg_ch == push_ch) &&
    !(pop_valid && pop_ch == push_ch) |=> ch_full[$past(push_ch)]);

  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && ch_empty[pop_ch] |=> !pop_dvalid);

  p_pop_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop_valid && !ch_empty[pop_ch] && !(frz_on && frz_ch == pop_ch) &&
    !(cfg_we && cfg_ch == pop_ch) |=> pop_dvalid);

  p_setup_empties_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> ch_empty[$past(cfg_ch)]);

  p_freeze_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frz_on && !peek_we && !(cfg_we && cfg_ch == frz_ch) |=> $stable(peek_ptrs));

  p_stat_matches_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_stat[10] == (peek_ptrs[PW-1:0] == peek_ptrs[16 +: PW]));
endmodule

bind cmd_ring_fifo cmd_ring_fifo_chk #(.NCH(NCH), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
  .push_valid(push_valid), .push_ch(push_ch), .pop_valid(pop_valid), .pop_ch(pop_ch),
  .pop_dvalid(pop_dvalid), .ch_empty(ch_empty), .ch_full(ch_full), .peek_we(peek_we),
  .peek_ptrs(peek_ptrs), .fifo_stat(fifo_stat), .pk_ctrl(pk_ctrl)
);

// File: tb/test_cmd_ring_fifo.sv
`timescale 1ns/1ps
module test_cmd_ring_fifo;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0, push_valid = 0, pop_valid = 0, peek_we = 0;
  logic [1:0]  cfg_ch = 0, push_ch = 0, pop_ch = 0;
  logic [31:0] cfg_wdata = 0, push_data = 0, peek_wdata = 0;
  logic        pop_dvalid;
  logic [31:0] pop_data, peek_ptrs, peek_data, fifo_stat;
  logic [3:0]  ch_empty, ch_full;

  always #4 clk = ~clk;

  cmd_ring_fifo i_cmd_ring_fifo (.*);

  int nvec = 0, nbad = 0;
  bit done = 0;
  int m_st[4], m_en[4], m_rp[4], m_wp[4];
  logic [31:0] m_mem [512];
  bit written [512];
  logic [31:0] m_pk;

  function automatic int nx(int p, int s, int e);
    return (p == e) ? s : (p + 1) % 512;
  endfunction
  function automatic bit mfull(int c);
    return nx(m_wp[c], m_st[c], m_en[c]) == m_rp[c];
  endfunction
  function automatic bit mempty(int c);
    return m_rp[c] == m_wp[c];
  endfunction
  function automatic bit frz(int c);
    return m_pk[31] && (int'(m_pk[17:16]) == c);
  endfunction

  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic step(string req, bit pv, int pc, logic [31:0] pd, bit ov, int oc,
                      bit cw, int cc, logic [31:0] cd, bit kw, logic [31:0] kd);
    bit e_push, e_pop, e_pk, pok, kok;
    logic [31:0] e_pd, e_kd;
    logic [3:0] xe, xf;
    int k;
    push_valid = pv; push_ch = 2'(pc); push_data = pd;
    pop_valid = ov; pop_ch = 2'(oc);
    cfg_we = cw; cfg_ch = 2'(cc); cfg_wdata = cd;
    peek_we = kw; peek_wdata = kd;
    e_push = pv && !mfull(pc) && !frz(pc) && !(cw && cc == pc);
    e_pop  = ov && !mempty(oc) && !frz(oc) && !(cw && cc == oc);
    e_pd = m_mem[m_rp[oc]]; pok = written[m_rp[oc]];
    e_pk = kw && kd[31];
    e_kd = m_mem[kd[8:0]]; kok = written[kd[8:0]];
    if (e_push) begin
      m_mem[m_wp[pc]] = pd; written[m_wp[pc]] = 1;
      m_wp[pc] = nx(m_wp[pc], m_st[pc], m_en[pc]);
    end
    if (e_pop) m_rp[oc] = nx(m_rp[oc], m_st[oc], m_en[oc]);
    if (cw) begin
      m_st[cc] = int'(cd[8:0]); m_en[cc] = int'(cd[24:16]);
      m_rp[cc] = m_st[cc]; m_wp[cc] = m_st[cc];
    end
    if (kw) m_pk = kd;
    @(posedge clk); #1;
    chk(req, "pop_dvalid", {31'b0, pop_dvalid}, {31'b0, e_pop});
    if (e_pop && pok) chk(req, "pop_data", pop_data, e_pd);
    if (e_pk && kok) chk(req, "peek_data", peek_data, e_kd);
    k = int'(m_pk[17:16]);
    chk(req, "peek_ptrs", peek_ptrs, {7'b0, 9'(m_wp[k]), 7'b0, 9'(m_rp[k])});
    chk(req, "fifo_stat", fifo_stat, {21'b0, mempty(k), 10'b0});
    for (int c = 0; c < 4; c++) begin xe[c] = mempty(c); xf[c] = mfull(c); end
    chk(req, "ch_empty", {28'b0, ch_empty}, {28'b0, xe});
    chk(req, "ch_full", {28'b0, ch_full}, {28'b0, xf});
  endtask

  task automatic idle(string req);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int c = 0; c < 4; c++) begin
      m_st[c] = c * 128; m_en[c] = c * 128 + 127; m_rp[c] = c * 128; m_wp[c] = c * 128;
    end
    m_pk = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    idle("R1");
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h8002_0000);
    step("R9", 1, 2, 32'hAAAA_0001, 0, 0, 0, 0, 0, 0, 0);
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    step("R10", 1, 2, 32'hAAAA_0002, 0, 0, 0, 0, 0, 0, 0);
    step("R2", 1, 1, 32'h1, 0, 0, 1, 1, 32'h000D_000A, 0, 0);
    for (int i = 0; i < 3; i++) step("R3", 1, 1, 32'hB000_0000 + i, 0, 0, 0, 0, 0, 0, 0);
    step("R3", 1, 1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0, 0, 0);
    step("R6", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0001_0000);
    for (int i = 0; i < 4; i++) step("R4", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) step("R5", 1, 1, 32'hC000_0000 + i, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 2; i++) step("R5", 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 32'hD000_0000, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 5; i++) step("R11", 1, 1, 32'hD100_0000 + i, 1, 1, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 32'hD200_0000, 0, 0, 0, 0, 0, 0, 0);
    step("R11", 1, 1, 32'hD300_0000, 1, 1, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h8001_000B);
    step("R9", 1, 1, 32'hE000_0000, 1, 1, 0, 0, 0, 0, 0);
    step("R9", 1, 2, 32'hE000_0001, 1, 2, 0, 0, 0, 0, 0);
    step("R7", 1, 2, 32'hE000_0002, 0, 0, 0, 0, 0, 1, 32'h8002_0000 | (32'(m_wp[2]) & 32'h1FF));
    step("R7", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h8002_0000 | (32'(m_wp[2] + 511) & 32'h1FF));
    step("R10", 0, 0, 0, 0, 0, 0, 0, 0, 1, 32'h0);
    step("R10", 1, 1, 32'hE000_0003, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(99));
      int s = int'($urandom_range(511));
      int l = int'($urandom_range(1, 16));
      bit cw = (r == 0);
      bit kw = (r >= 95);
      logic [31:0] kd = (r >= 98) ? 32'h0 :
                        (32'h8000_0000 | ($urandom_range(3) << 16) | $urandom_range(511));
      if (s + l > 512) s = 512 - l;
      step("R4/R6/R7/R8", $urandom_range(99) < 60, int'($urandom_range(3)), $urandom,
           $urandom_range(99) < 45, int'($urandom_range(3)),
           cw, int'($urandom_range(3)), {7'b0, 9'(s + l - 1), 7'b0, 9'(s)}, kw, kd);
    end
    idle("R4");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule